// File: doc/BRIEF.md
# Condition Flag Store and Branch Condition Evaluator

This block keeps a small set of one-bit condition flags next to an integer ALU and turns them into branch decisions. Whenever the ALU performs an operation that is marked as flag-setting, the block derives sign, zero and parity from the ALU result. It also takes carry and overflow from the ALU's own outputs, and latches all five together on the clock edge. A compare is simply a subtraction whose result is thrown away while its flags are kept. A later conditional branch therefore needs no compare of its own when the preceding operation already left the right flags behind.

The branch side is purely combinational. A 4-bit condition code selects a predicate over the stored flags, and `br_taken` answers it in the same cycle. The predicates include the six signed relations (equal, not equal, less, less-or-equal, greater, greater-or-equal), a code that is always taken, a code that is never taken, and eight codes that test a single flag directly. Parity is counted over the low eight result bits only, whatever the datapath width.

Top module: `cond_flag_unit`

## Requirements
- R1: When `flag_we` is high at a rising clock edge, `flag_s` afterwards equals the most significant bit of `alu_result` sampled at that edge.
- R2: When `flag_we` is high at a rising clock edge, `flag_z` afterwards is 1 exactly when every bit of the sampled `alu_result` is 0.
- R3: When `flag_we` is high at a rising clock edge, `flag_c` afterwards equals the sampled `alu_carry` and `flag_v` equals the sampled `alu_ovf`.
- R4: When `flag_we` is high at a rising clock edge, `flag_p` afterwards is 1 exactly when bits 7..0 of the sampled `alu_result` hold an even number of ones. Bits above 7 have no effect on it.
- R5: At a rising edge with `flag_we` low, all five flags keep their values, whatever the ALU inputs do.
- R6: While `rst_n` is low, all five flags are 0. With all flags 0, code 3 is taken and code 2 is not.
- R7: Code 2 (equal) is taken when Z=1. Code 3 (not equal) is taken when Z=0.
- R8: Code 4 (signed less) is taken when S differs from V. Code 5 (signed greater-or-equal) is taken when S equals V. After the flags of a subtraction a−b, these codes give the signed comparison of a and b.
- R9: Code 6 (signed less-or-equal) is taken when Z=1 or S differs from V. Code 7 (signed greater) is taken when Z=0 and S equals V.
- R10: Code 0 is never taken and code 1 is always taken, regardless of the flags.
- R11: Codes 8/9 are taken on C=1/C=0, codes 10/11 on P=1/P=0, codes 12/13 on S=1/S=0, and codes 14/15 on V=1/V=0.
- R12: `br_taken` depends only on the stored flags and `br_cond`. A change of `br_cond` shows in the same cycle, and it reflects a flag write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the flags |
| alu_result | input | DATA_W (32) | Result of the current ALU operation |
| alu_carry | input | 1 | Carry out of the current ALU operation |
| alu_ovf | input | 1 | Signed overflow of the current ALU operation |
| flag_we | input | 1 | The current operation sets the flags |
| br_cond | input | 4 | Branch condition code |
| flag_s | output | 1 | Stored sign flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_p | output | 1 | Stored parity flag |
| flag_v | output | 1 | Stored overflow flag |
| br_taken | output | 1 | Selected condition holds on the stored flags |

## Verification
The flag combinations are the hardest part to reach from the ports. The flags can only be set by result values, so states such as zero with parity clear, or sign with overflow in a particular relation, need results chosen with care. A 32-bit result whose low byte is zero while its upper bits are not must give Z=0 and P=1. The stimulus combines a multiplicative sweep of results, hand-placed edge values, and carry and overflow bits toggled independently, and tests all sixteen codes after each write. A separate sweep computes subtractions of signed operand pairs around zero and the extremes of the range, and checks the relational codes against the bench's own signed comparison.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic p;
    logic v;
  } cfu_flags_t;

  typedef enum logic [3:0] {
    CND_NEVER  = 4'd0,
    CND_ALWAYS = 4'd1,
    CND_EQ     = 4'd2,
    CND_NE     = 4'd3,
    CND_LT     = 4'd4,
    CND_GE     = 4'd5,
    CND_LE     = 4'd6,
    CND_GT     = 4'd7,
    CND_CSET   = 4'd8,
    CND_CCLR   = 4'd9,
    CND_PEVEN  = 4'd10,
    CND_PODD   = 4'd11,
    CND_NEG    = 4'd12,
    CND_POS    = 4'd13,
    CND_VSET   = 4'd14,
    CND_VCLR   = 4'd15
  } cfu_cond_e;

  // Signed "less" relation held by the flags after a subtraction.
  function automatic logic cfu_signed_lt(input cfu_flags_t f);
    return f.s ^ f.v;
  endfunction

  // Predicate selected by a condition code.
  function automatic logic cfu_take(input cfu_cond_e cnd, input cfu_flags_t f);
    logic lt;
    lt = cfu_signed_lt(f);
    case (cnd)
      CND_NEVER:  return 1'b0;
      CND_ALWAYS: return 1'b1;
      CND_EQ:     return f.z;
      CND_NE:     return ~f.z;
      CND_LT:     return lt;
      CND_GE:     return ~lt;
      CND_LE:     return f.z | lt;
      CND_GT:     return ~f.z & ~lt;
      CND_CSET:   return f.c;
      CND_CCLR:   return ~f.c;
      CND_PEVEN:  return f.p;
      CND_PODD:   return ~f.p;
      CND_NEG:    return f.s;
      CND_POS:    return ~f.s;
      CND_VSET:   return f.v;
      default:    return ~f.v;
    endcase
  endfunction

endpackage

// File: rtl/cfu_flag_gen.sv
module cfu_flag_gen
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              ovf,
  output cfu_flags_t        flags
);
  localparam int MSB = DATA_W - 1;

  logic res_is_zero;
  logic low_even;

  assign res_is_zero = (result == '0);
  assign low_even    = ~^result[PAR_W-1:0];

  always_comb begin
    flags.s = result[MSB];
    flags.z = res_is_zero;
    flags.c = carry;
    flags.p = low_even;
    flags.v = ovf;
  end

  // R2: a zero result cannot carry a sign bit
  always_comb begin
    if (res_is_zero) a_r2_zero_not_neg : assert (!flags.s);
  end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
  import cfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  cfu_flags_t nxt,
  output cfu_flags_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur <= '0;
    else if (we) cur <= nxt;
  end

  // R5: without a write the stored flags do not move
  a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cur));
endmodule

// File: rtl/cfu_branch_eval.sv
module cfu_branch_eval
  import cfu_pkg::*;
(
  input  cfu_flags_t flags,
  input  logic [3:0] cond,
  output logic       taken
);
  cfu_cond_e cnd;

  assign cnd   = cfu_cond_e'(cond);
  assign taken = cfu_take(cnd, flags);

  // R10: the fixed codes ignore the flags
  always_comb begin
    if (cnd == CND_NEVER)  a_r10_never  : assert (!taken);
    if (cnd == CND_ALWAYS) a_r10_always : assert (taken);
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              flag_we,
  input  logic [3:0]        br_cond,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_p,
  output logic              flag_v,
  output logic              br_taken
);
  localparam int MSB = DATA_W - 1;

  cfu_flags_t next_flags;
  cfu_flags_t held_flags;

  cfu_flag_gen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_gen (
    .result (alu_result),
    .carry  (alu_carry),
    .ovf    (alu_ovf),
    .flags  (next_flags)
  );

  cfu_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .nxt   (next_flags),
    .cur   (held_flags)
  );

  cfu_branch_eval u_eval (
    .flags (held_flags),
    .cond  (br_cond),
    .taken (br_taken)
  );

  assign flag_s = held_flags.s;
  assign flag_z = held_flags.z;
  assign flag_c = held_flags.c;
  assign flag_p = held_flags.p;
  assign flag_v = held_flags.v;

  a_r1_sign : assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flag_s == $past(alu_result[MSB]));

  a_r2_zero : assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flag_z == ($past(alu_result) == '0));

  a_r3_carry_ovf : assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flag_c == $past(alu_carry)) && (flag_v == $past(alu_ovf)));

  a_r4_parity : assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flag_p == ($countones($past(alu_result[PAR_W-1:0])) % 2 == 0));

  a_r7_equal : assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond == 4'd2) |-> br_taken == flag_z);

  a_r8_less : assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond == 4'd4) |-> br_taken == (flag_s != flag_v));
endmodule

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
  localparam int  W   = 32;
  localparam time CYC = 20ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] alu_result = '0;
  logic         alu_carry = 1'b0;
  logic         alu_ovf = 1'b0;
  logic         flag_we = 1'b0;
  logic [3:0]   br_cond = 4'd0;
  logic         flag_s, flag_z, flag_c, flag_p, flag_v, br_taken;

  int n_checks = 0;
  int n_fail   = 0;

  cond_flag_unit #(.DATA_W(W), .PAR_W(8)) i_cond_flag_unit (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .flag_we(flag_we), .br_cond(br_cond),
    .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c), .flag_p(flag_p),
    .flag_v(flag_v), .br_taken(br_taken)
  );

  always #(CYC/2) clk = ~clk;

  // bench model of the flags: {s,z,c,p,v}
  logic [4:0] model;

  function automatic logic [4:0] calc_flags(input logic [W-1:0] r, input logic c, input logic v);
    int ones = 0;
    for (int b = 0; b < 8; b++) ones += int'(r[b]);
    return {r[W-1], r == 0, c, (ones % 2) == 0, v};
  endfunction

  function automatic logic want_taken(input int code, input logic [4:0] f);
    logic s, z, c, p, v;
    {s, z, c, p, v} = f;
    if (code == 0) return 0;
    if (code == 1) return 1;
    if (code == 2) return z;
    if (code == 3) return !z;
    if (code == 4) return s != v;
    if (code == 5) return s == v;
    if (code == 6) return z || (s != v);
    if (code == 7) return !z && (s == v);
    if (code == 8 || code == 9)   return c == (code == 8);
    if (code == 10 || code == 11) return p == (code == 10);
    if (code == 12 || code == 13) return s == (code == 12);
    return v == (code == 14);
  endfunction

  task automatic check_flags(input string req);
    n_checks++;
    if ({flag_s, flag_z, flag_c, flag_p, flag_v} !== model) begin
      n_fail++;
      $display("FAIL %s flags szcpv actual %b expected %b", req,
               {flag_s, flag_z, flag_c, flag_p, flag_v}, model);
    end
  endtask

  // R7 R8 R9 R10 R11 R12: every code answered combinationally on stored flags
  task automatic check_codes(input string req);
    for (int k = 0; k < 16; k++) begin
      br_cond = 4'(k);
      #1;
      n_checks++;
      if (br_taken !== want_taken(k, model)) begin
        n_fail++;
        $display("FAIL %s code %0d flags %b actual %b expected %b", req, k, model,
                 br_taken, want_taken(k, model));
      end
    end
  endtask

  task automatic write_op(input logic [W-1:0] r, input logic c, input logic v);
    @(negedge clk);
    alu_result = r; alu_carry = c; alu_ovf = v; flag_we = 1'b1;
    @(negedge clk);
    flag_we = 1'b0;
    model = calc_flags(r, c, v);
  endtask

  initial begin
    #(CYC*200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [32:0] d;
    logic signed [W-1:0] opa, opb;
    logic [W-1:0] ops [10];
    model = '0;
    repeat (2) @(negedge clk);
    // R6: reset state
    check_flags("R6");
    br_cond = 4'd3; #1; n_checks++;
    if (br_taken !== 1'b1) begin n_fail++; $display("FAIL R6 NE taken actual %b expected 1", br_taken); end
    br_cond = 4'd2; #1; n_checks++;
    if (br_taken !== 1'b0) begin n_fail++; $display("FAIL R6 EQ taken actual %b expected 0", br_taken); end
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R4: fixed edge results
    write_op(32'h0000_0000, 1'b0, 1'b0); check_flags("R2"); check_codes("R7");
    write_op(32'h8000_0000, 1'b1, 1'b0); check_flags("R1"); check_codes("R8");
    write_op(32'h0000_0100, 1'b0, 1'b1); check_flags("R4"); check_codes("R9");
    write_op(32'hFFFF_FF01, 1'b1, 1'b1); check_flags("R4"); check_codes("R11");
    write_op(32'h7FFF_FFFF, 1'b0, 1'b1); check_flags("R3"); check_codes("R10");

    // sweep of results with independent carry and overflow
    for (int i = 0; i < 300; i++) begin
      write_op(32'(i) * 32'h9E37_79B1 ^ 32'(i), i[0], i[1]);
      check_flags("R1-sweep R2 R3 R4");
      check_codes("R12");
    end

    // R5: flags hold while the enable is low
    write_op(32'h8000_0003, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      alu_result = 32'(i); alu_carry = ~alu_carry; alu_ovf = ~alu_ovf;
      @(negedge clk);
      check_flags("R5");
    end
    check_codes("R5");

    // R8 R9 R7: subtraction compares over signed operand pairs
    ops = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h2, 32'hFFFF_FFFE,
            32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFE, 32'h8000_0001, 32'h0001_0000};
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        opa = ops[a]; opb = ops[b];
        d = {1'b0, opa} - {1'b0, opb};
        write_op(d[W-1:0], d[32], (opa[W-1] != opb[W-1]) && (d[W-1] != opa[W-1]));
        br_cond = 4'd4; #1; n_checks++;
        if (br_taken !== (opa < opb)) begin n_fail++;
          $display("FAIL R8 %0d<%0d actual %b expected %b", opa, opb, br_taken, opa < opb); end
        br_cond = 4'd7; #1; n_checks++;
        if (br_taken !== (opa > opb)) begin n_fail++;
          $display("FAIL R9 %0d>%0d actual %b expected %b", opa, opb, br_taken, opa > opb); end
        br_cond = 4'd6; #1; n_checks++;
        if (br_taken !== (opa <= opb)) begin n_fail++;
          $display("FAIL R9 %0d<=%0d actual %b expected %b", opa, opb, br_taken, opa <= opb); end
        br_cond = 4'd2; #1; n_checks++;
        if (br_taken !== (opa == opb)) begin n_fail++;
          $display("FAIL R7 %0d==%0d actual %b expected %b", opa, opb, br_taken, opa == opb); end
      end
    end

    // R6: asynchronous reset in mid-run
    write_op(32'hFFFF_FFFF, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0; #1;
    model = '0;
    check_flags("R6");
    check_codes("R6");
    @(negedge clk); rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule